// File: doc/BRIEF.md
# Programmable Three-Channel Color Space Converter

This block converts a stream of pixels from one three-component colour space to another, one pixel per clock. Each of the three output components is a weighted sum of all three input components plus an offset. The weights are signed fixed-point values with twelve fractional bits. A shared gain setting multiplies every weight and every offset by one, two or four, so that matrices with entries above unity can be expressed. The result is clamped to the unsigned 12-bit output range.

Software or a sequencer loads the twelve weights and offsets and the gain through a simple write port. The writes land in a staging bank. The staging bank is copied into the working bank only when a pixel flagged as the start of a frame enters the block, so a frame is never processed with a half-updated matrix. Pixels move through a fixed three-stage pipeline, and a valid flag travels alongside them.

Top module: `csc3x3`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid` is 0 and all three output components are 0. Reset clears every staged and working weight, every offset and the gain code to 0.
- R2: Each pixel accepted with `in_valid`=1 produces exactly one output with `out_valid`=1, three rising edges after the edge that sampled it. Back-to-back pixels give back-to-back outputs. Input data with `in_valid`=0 produces no output. While `out_valid` is 0, the output components hold their last value.
- R3: Output channel j equals clamp(round_half_up(G·(kj0·in_r + kj1·in_g + kj2·in_b)/4096) + G·kj3). Here G is the gain, the inputs are unsigned, and round_half_up(x) = floor(x + 0.5). All three outputs are computed from the same input pixel.
- R4: The weights and offsets are 13-bit two's complement values. For example, 13'h1000 is −4096, which means −1.0 as a weight and −4096 as an offset.
- R5: The 2-bit gain code sets G. Code 0 gives ×1, code 1 gives ×2, code 2 gives ×4, and code 3 behaves exactly like code 2. The gain scales the offset as well as the weighted sum.
- R6: A result below 0 saturates to 0, and a result above 4095 saturates to 4095. Results never wrap.
- R7: Write address map. For address 4·j+i with j in 0..2 and i in 0..2, the write sets the weight of input i (0=r, 1=g, 2=b) for output j (0=out_r, 1=out_g, 2=out_b). Address 4·j+3 sets the offset of output j. Address 12 sets the gain code from `wr_data[1:0]`. Writes to addresses 13 to 15 have no effect.
- R8: Writes change only the staging bank. The working bank loads the staging bank on a pixel with `in_valid`=1 and `in_sof`=1, and that pixel already uses the new values. Pixels without `in_sof` use the previous working values. A write issued on the same clock as a frame-start pixel takes effect at the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 13 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input pixel starts a frame; commits staged settings |
| in_r | input | 12 | Input component 0 |
| in_g | input | 12 | Input component 1 |
| in_b | input | 12 | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Output component 0 |
| out_g | output | 12 | Output component 1 |
| out_b | output | 12 | Output component 2 |

## Verification
The bench builds the block with its default parameters: 12-bit components, 13-bit weights and twelve fractional bits. At these values every weight extreme can be reached. A weight of −4096 drives the sum fully negative. Full-scale inputs under gain ×4 push the sum past the output range, and odd inputs against half weights land exactly on a rounding midpoint. Together these exercise both saturation limits and the round-half-up rule. The 13-bit offsets are wide enough to move the result across either clamp on their own.

// File: rtl/csc_pkg.sv
package csc_pkg;

  // Output channels and terms per channel (three weights plus one offset).
  localparam int N_CH   = 3;
  localparam int N_TERM = 4;
  localparam int N_REG  = N_CH * N_TERM;

  // Gain code and the left shift it selects.
  localparam int GAIN_W  = 2;
  localparam int MAX_SH  = 2;

  typedef enum logic [GAIN_W-1:0] {
    GAIN_X1  = 2'd0,
    GAIN_X2  = 2'd1,
    GAIN_X4  = 2'd2,
    GAIN_X4B = 2'd3
  } gain_e;

  function automatic logic [GAIN_W-1:0] gain_shift(input logic [GAIN_W-1:0] code);
    case (gain_e'(code))
      GAIN_X1:  gain_shift = 2'd0;
      GAIN_X2:  gain_shift = 2'd1;
      default:  gain_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/csc_cfg_bank.sv
module csc_cfg_bank
  import csc_pkg::*;
#(
  parameter int CW    = 13,
  parameter int ADDRW = 4,
  localparam int KW   = N_REG * CW,
  localparam int FW   = KW + GAIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDRW-1:0]  wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              commit,
  output logic [KW-1:0]     eff_k,
  output logic [GAIN_W-1:0] eff_gain,
  output logic [FW-1:0]     act_flat
);

  logic [KW-1:0]     shd_k;
  logic [KW-1:0]     act_k;
  logic [GAIN_W-1:0] shd_gain;
  logic [GAIN_W-1:0] act_gain;

  // One staging word per weight/offset, each with its own address decode.
  for (genvar i = 0; i < N_REG; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        shd_k[i*CW +: CW] <= '0;
      else if (wr_en && (wr_addr == ADDRW'(i)))
        shd_k[i*CW +: CW] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      shd_gain <= '0;
    else if (wr_en && (wr_addr == ADDRW'(N_REG)))
      shd_gain <= wr_data[GAIN_W-1:0];
  end

  // Working bank: copied only on a frame-start pixel.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_k    <= '0;
      act_gain <= '0;
    end else if (commit) begin
      act_k    <= shd_k;
      act_gain <= shd_gain;
    end
  end

  // The frame-start pixel itself sees the staged values.
  always_comb begin
    eff_k    = commit ? shd_k    : act_k;
    eff_gain = commit ? shd_gain : act_gain;
  end

  assign act_flat = {act_gain, act_k};

endmodule

// File: rtl/csc_lane.sv
module csc_lane
  import csc_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CW   = 13,
  parameter int FRAC = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en1,
  input  logic                 en2,
  input  logic                 en3,
  input  logic [DW-1:0]        x0,
  input  logic [DW-1:0]        x1,
  input  logic [DW-1:0]        x2,
  input  logic signed [CW-1:0] k0,
  input  logic signed [CW-1:0] k1,
  input  logic signed [CW-1:0] k2,
  input  logic signed [CW-1:0] koff,
  input  logic [GAIN_W-1:0]    sh,
  output logic [DW-1:0]        y
);

  localparam int PW = CW + DW + 1;          // one signed product
  localparam int AW = PW + 2 + MAX_SH;      // sum of three, after gain
  localparam int OW = CW + MAX_SH;          // scaled offset
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< DW) - AW'(1);

  // Stage 1: products and scaled offset
  logic signed [PW-1:0]  p0_q, p1_q, p2_q;
  logic signed [OW-1:0]  off_q;
  logic [GAIN_W-1:0]     sh_q;
  // Stage 2: rounded sum plus offset
  logic signed [AW-1:0]  sum_c, rnd_c;
  logic signed [AW-1:0]  res_q;
  // Stage 3: clamp
  logic [DW-1:0]         sat_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_q  <= '0;
      p1_q  <= '0;
      p2_q  <= '0;
      off_q <= '0;
      sh_q  <= '0;
    end else if (en1) begin
      p0_q  <= PW'(k0) * PW'($signed({1'b0, x0}));
      p1_q  <= PW'(k1) * PW'($signed({1'b0, x1}));
      p2_q  <= PW'(k2) * PW'($signed({1'b0, x2}));
      off_q <= OW'(koff) <<< sh;
      sh_q  <= sh;
    end
  end

  always_comb begin
    sum_c = (AW'(p0_q) + AW'(p1_q) + AW'(p2_q)) <<< sh_q;
    rnd_c = (sum_c + HALF) >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst)
      res_q <= '0;
    else if (en2)
      res_q <= rnd_c + AW'(off_q);
  end

  always_comb begin
    if (res_q < 0)
      sat_c = '0;
    else if (res_q > MAXV)
      sat_c = '1;
    else
      sat_c = res_q[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      y <= '0;
    else if (en3)
      y <= sat_c;
  end

endmodule

// File: rtl/csc3x3.sv
module csc3x3
  import csc_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 13,
  parameter int FRAC  = 12,
  parameter int ADDRW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ADDRW-1:0] wr_addr,
  input  logic [CW-1:0]    wr_data,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [DW-1:0]    in_r,
  input  logic [DW-1:0]    in_g,
  input  logic [DW-1:0]    in_b,
  output logic             out_valid,
  output logic [DW-1:0]    out_r,
  output logic [DW-1:0]    out_g,
  output logic [DW-1:0]    out_b
);

  localparam int KW   = N_REG * CW;
  localparam int CFGW = KW + GAIN_W;

  logic              commit;
  logic [KW-1:0]     eff_k;
  logic [GAIN_W-1:0] eff_gain;
  logic [CFGW-1:0]   act_flat;
  logic [GAIN_W-1:0] shift;
  logic              v1_q, v2_q;
  logic [DW-1:0]     y [N_CH];

  assign commit = in_valid && in_sof;
  assign shift  = gain_shift(eff_gain);

  csc_cfg_bank #(.CW(CW), .ADDRW(ADDRW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .commit   (commit),
    .eff_k    (eff_k),
    .eff_gain (eff_gain),
    .act_flat (act_flat)
  );

  // Valid flag shadows the three datapath stages.
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= in_valid;
      v2_q      <= v1_q;
      out_valid <= v2_q;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
    csc_lane #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en1  (in_valid),
      .en2  (v1_q),
      .en3  (v2_q),
      .x0   (in_r),
      .x1   (in_g),
      .x2   (in_b),
      .k0   (eff_k[(ch*N_TERM + 0)*CW +: CW]),
      .k1   (eff_k[(ch*N_TERM + 1)*CW +: CW]),
      .k2   (eff_k[(ch*N_TERM + 2)*CW +: CW]),
      .koff (eff_k[(ch*N_TERM + 3)*CW +: CW]),
      .sh   (shift),
      .y    (y[ch])
    );
  end

  assign out_r = y[0];
  assign out_g = y[1];
  assign out_b = y[2];

endmodule

// File: rtl/csc3x3_chk.sv
module csc3x3_chk #(
  parameter int DW   = 12,
  parameter int CFGW = 158
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_sof,
  input logic            out_valid,
  input logic [DW-1:0]   out_r,
  input logic [DW-1:0]   out_g,
  input logic [DW-1:0]   out_b,
  input logic [CFGW-1:0] act_flat
);

  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)
      since_rst <= '0;
    else if (since_rst != 2'd3)
      since_rst <= since_rst + 2'd1;
  end

  // R1: reset clears the output side
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_r == '0 && out_g == '0 && out_b == '0));

  // R2: valid emerges exactly three edges after acceptance
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R2: outputs hold while no pixel is emitted
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !out_valid) |-> $stable({out_r, out_g, out_b}));

  // R8: working settings only move on a frame-start pixel
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !(in_valid && in_sof)) |=> $stable(act_flat));

  // R3: emitted pixels carry defined data
  p_known_out_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown({out_r, out_g, out_b}));

endmodule

bind csc3x3 csc3x3_chk #(.DW(DW), .CFGW(CFGW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b),
  .act_flat  (act_flat)
);

// File: tb/csc3x3_tb_top.sv
module csc3x3_tb_top;

  localparam int DW = 12;
  localparam int CW = 13;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic [DW-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic          out_valid;
  logic [DW-1:0] out_r, out_g, out_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  csc3x3 dut_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .in_sof(in_sof),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // Fixed matrix used by the table (R3, R4):
  //   out_r = 0.5*r ; out_g = -1.0*g + 1000 ; out_b = 0.25*(r+g+b) - 100
  // Entry: {gain, r, g, b, exp_r, exp_g, exp_b}
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 12'd100,  12'd100,  12'd100,  12'd50,   12'd900,  12'd0   },
    {2'd0, 12'd101,  12'd0,    12'd0,    12'd51,   12'd1000, 12'd0   },
    {2'd0, 12'd4095, 12'd4095, 12'd4095, 12'd2048, 12'd0,    12'd2971},
    {2'd1, 12'd4095, 12'd0,    12'd4095, 12'd4095, 12'd2000, 12'd3895},
    {2'd1, 12'd3000, 12'd500,  12'd1000, 12'd3000, 12'd1000, 12'd2050},
    {2'd2, 12'd3000, 12'd0,    12'd0,    12'd4095, 12'd4000, 12'd2600},
    {2'd2, 12'd1,    12'd1000, 12'd1,    12'd2,    12'd0,    12'd602 },
    {2'd3, 12'd1,    12'd1000, 12'd1,    12'd2,    12'd0,    12'd602 },
    {2'd2, 12'd0,    12'd0,    12'd4095, 12'd0,    12'd4000, 12'd3695},
    {2'd0, 12'd3,    12'd0,    12'd0,    12'd2,    12'd1000, 12'd0   }
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 4'(addr);
    wr_data = CW'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Send one pixel alone, confirm the latency, leave outputs ready to sample.
  task automatic pixel(input bit sof, input int r, input int g, input int b, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof;
    in_r = DW'(r); in_g = DW'(g); in_b = DW'(b);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    @(negedge clk);
    check({req, " valid low before third edge"}, int'(out_valid), 0);
    @(negedge clk);
    check({req, " valid after third edge"}, int'(out_valid), 1);
  endtask

  task automatic expect3(input string req, input int er, input int eg, input int eb);
    check({req, " out_r"}, int'(out_r), er);
    check({req, " out_g"}, int'(out_g), eg);
    check({req, " out_b"}, int'(out_b), eb);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 out_valid in reset", int'(out_valid), 0);
    expect3("R1 reset", 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    // R1: cleared settings give zero output
    pixel(1'b1, 4095, 4095, 4095, "R1 cleared bank");
    expect3("R1 cleared bank", 0, 0, 0);

    // R7, R4: load the matrix
    wr(0, 2048);  wr(1, 0);     wr(2, 0);     wr(3, 0);
    wr(4, 0);     wr(5, 'h1000); wr(6, 0);    wr(7, 1000);
    wr(8, 1024);  wr(9, 1024);  wr(10, 1024); wr(11, 'h1F9C);

    // Table: R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      wr(12, int'(VEC[i][73:72]));
      pixel(1'b1, int'(VEC[i][71:60]), int'(VEC[i][59:48]), int'(VEC[i][47:36]), "R3 R5 R6 table");
      expect3($sformatf("R3 R4 R5 R6 vector %0d", i),
              int'(VEC[i][35:24]), int'(VEC[i][23:12]), int'(VEC[i][11:0]));
    end

    // R8: staged offset not used until frame start
    wr(3, 500);
    pixel(1'b0, 100, 0, 0, "R8 no sof");
    expect3("R8 staged offset unused", 50, 1000, 0);
    pixel(1'b1, 100, 0, 0, "R8 sof");
    expect3("R8 offset applied on sof", 550, 1000, 0);

    // R8: staged gain not used until frame start
    wr(12, 1);
    pixel(1'b0, 100, 0, 0, "R8 gain no sof");
    expect3("R8 staged gain unused", 550, 1000, 0);
    pixel(1'b1, 100, 0, 0, "R8 gain sof");
    expect3("R8 R5 gain x2 applied", 1100, 2000, 0);
    wr(12, 0);

    // R8: write on the same clock as a frame start waits for the next one
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd7; wr_data = 13'd0;
    in_valid = 1'b1; in_sof = 1'b1; in_r = 12'd100; in_g = '0; in_b = '0;
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 same-clock write valid", int'(out_valid), 1);
    expect3("R8 same-clock write deferred", 550, 1000, 0);
    pixel(1'b1, 100, 0, 0, "R8 next sof");
    expect3("R8 deferred write applied", 550, 0, 0);
    wr(7, 1000);

    // R7: unmapped addresses change nothing
    wr(13, 'h0FFF); wr(14, 'h1FFF); wr(15, 'h0ABC);
    pixel(1'b1, 100, 0, 0, "R7 unmapped");
    expect3("R7 unmapped writes ignored", 550, 1000, 0);

    // R2: back-to-back stream, then idle with changing data
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b0; in_r = 12'd10;
    @(negedge clk); in_r = 12'd20;
    @(negedge clk); in_r = 12'd30;
    @(negedge clk);
    in_valid = 1'b0; in_r = 12'd4000; in_g = 12'd77;
    check("R2 stream valid 0", int'(out_valid), 1);
    check("R2 stream out 0", int'(out_r), 505);
    @(negedge clk); in_r = 12'd1234;
    check("R2 stream valid 1", int'(out_valid), 1);
    check("R2 stream out 1", int'(out_r), 510);
    @(negedge clk); in_b = 12'd999;
    check("R2 stream valid 2", int'(out_valid), 1);
    check("R2 stream out 2", int'(out_r), 515);
    repeat (3) begin
      @(negedge clk);
      check("R2 invalid input gives no output", int'(out_valid), 0);
      expect3("R2 outputs hold when idle", 515, 1000, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule